// File: doc/BRIEF.md
# Display Line Fetch Bus Master

This block reads one display line of pixel data from display memory and hands the words to a 24-bit pixel stream. A line-start pulse triggers it. The block then takes a snapshot of the segment count, the pixel-depth code, the memory kind, the wait-state count and the start address. From the segment count and the depth it works out how many bus words the line occupies.

The block then becomes the bus master. It raises a request that holds the processor off and waits for the grant. It spends the fixed per-line overhead of the selected memory kind. It then reads the words back to back, using the timing of that memory kind. After the last word it drops the request and reports, for that line, how many cycles the bus was held. That count divided by the line period gives the processor's bus occupancy. Memory kinds are 16-bit external static RAM with programmable waits, 32-bit on-chip RAM with an extra cycle on every block crossing, and 16-bit synchronous DRAM with a fixed per-line overhead.

Top module: `line_fetch_master`

## Requirements
- R1: The number of words read per line, and of pix_valid beats, is ceil(seg_count × bpp / W). W is 32 for on-chip RAM and 16 otherwise. bpp is set by depth_code: 0→1, 1→2, 2→4, 3→8, 4→12, 5→16, 6→24, 7→24.
- R2: bus_req rises in the cycle after an accepted line_start. mem_rd is only ever asserted while bus_req is high, and never before the grant is seen.
- R3: mem_kind 0 (and 3) selects 16-bit static RAM. Every word takes 2 + wait_cycles cycles, with no line overhead.
- R4: mem_kind 1 selects 32-bit on-chip RAM. Every word takes 1 cycle, the line adds 1 overhead cycle, and each read whose address bits above the BLK_BYTES offset differ from those of the previous read adds 1 cycle.
- R5: mem_kind 2 selects 16-bit synchronous DRAM. Every word takes 1 cycle, and the line adds 9 overhead cycles at its start.
- R6: stall_cycles latches the cycles from the grant up to the release, and excludes any wait for the grant. The latch happens together with a one-cycle line_done pulse, and bus_req is already low in that cycle. Configuration inputs are sampled only at the accepted line_start.
- R7: A line_start that arrives while a line is in progress is ignored: it changes neither the word count nor the stall count. It sets overrun, and overrun clears when the next line_start is accepted.
- R8: Word i is read at base_addr + i × (4 for on-chip RAM, else 2). It is emitted one cycle after its last read cycle: on-chip RAM gives mem_rdata[23:0], the 16-bit kinds give {8'h00, mem_rdata[15:0]}.
- R9: After reset, bus_req, mem_rd, pix_valid, line_done and overrun are 0, and stall_cycles is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Pulse that starts a line fetch |
| seg_count | input | SEG_W | Segments (pixels) in the line |
| depth_code | input | 3 | Pixel depth selector |
| mem_kind | input | 2 | Memory kind selector |
| wait_cycles | input | WAIT_W | Wait states for static RAM |
| base_addr | input | ADDR_W | Byte address of the line's first word |
| bus_grant | input | 1 | Bus grant from the arbiter |
| bus_req | output | 1 | Bus request, holds the processor off |
| mem_rd | output | 1 | Read strobe |
| mem_addr | output | ADDR_W | Read byte address |
| mem_rdata | input | 32 | Read data |
| pix_valid | output | 1 | Pixel word valid |
| pix_data | output | 24 | Pixel word |
| line_done | output | 1 | One-cycle end-of-line pulse |
| stall_cycles | output | STALL_W | Bus-held cycles of the last line |
| overrun | output | 1 | A line_start was dropped while busy |

## Verification
The bench builds the block with BLK_BYTES set to 256 instead of 4096. One long on-chip RAM line can therefore cross three block boundaries, and a short line that stays inside one block gives the case without crossings. The default widths are kept (11-bit segment count, 4-bit waits). This covers lines of a single word up to hundreds of words, every depth code, and static-RAM waits up to five, all with a bench-computed stall count.

// File: rtl/lf_pkg.sv
package lf_pkg;

    typedef enum logic [1:0] {
        MEM_SRAM16  = 2'd0,
        MEM_IRAM32  = 2'd1,
        MEM_SDRAM16 = 2'd2,
        MEM_SRAM16B = 2'd3
    } mem_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_OVH,
        ST_READ
    } fetch_st_e;

    localparam int unsigned SDRAM_LINE_OVH = 9;
    localparam int unsigned IRAM_LINE_OVH  = 1;

    function automatic logic [4:0] depth_bits(input logic [2:0] code);
        case (code)
            3'd0:    return 5'd1;
            3'd1:    return 5'd2;
            3'd2:    return 5'd4;
            3'd3:    return 5'd8;
            3'd4:    return 5'd12;
            3'd5:    return 5'd16;
            default: return 5'd24;
        endcase
    endfunction

    function automatic logic is_wide(input mem_kind_e k);
        return k == MEM_IRAM32;
    endfunction

endpackage

// File: rtl/lf_len_calc.sv
module lf_len_calc
    import lf_pkg::*;
#(
    parameter int SEG_W   = 11,
    parameter int WORDS_W = SEG_W + 1
) (
    input  logic [SEG_W-1:0]   seg,
    input  logic [2:0]         depth,
    input  mem_kind_e          kind,
    output logic [WORDS_W-1:0] words
);
    localparam int BITS_W = SEG_W + 6;

    logic [BITS_W-1:0] line_bits;

    always_comb begin
        line_bits = BITS_W'(seg) * BITS_W'(depth_bits(depth));
        if (is_wide(kind))
            words = WORDS_W'((line_bits + BITS_W'(31)) >> 5);
        else
            words = WORDS_W'((line_bits + BITS_W'(15)) >> 4);
    end

endmodule

// File: rtl/lf_stall_meter.sv
module lf_stall_meter #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         active,
    input  logic         finish,
    output logic [W-1:0] stall_q,
    output logic         done_q
);
    logic [W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            stall_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= finish;
            if (clear)
                run_cnt <= '0;
            else if (active)
                run_cnt <= run_cnt + W'(1);
            if (finish)
                stall_q <= run_cnt + W'(1);
        end
    end

    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
    p_done_after_active_r6: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(active));

endmodule

// File: rtl/line_fetch_master.sv
module line_fetch_master
    import lf_pkg::*;
#(
    parameter int SEG_W     = 11,
    parameter int WAIT_W    = 4,
    parameter int ADDR_W    = 24,
    parameter int BLK_BYTES = 4096,
    parameter int STALL_W   = SEG_W + WAIT_W + 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               line_start,
    input  logic [SEG_W-1:0]   seg_count,
    input  logic [2:0]         depth_code,
    input  logic [1:0]         mem_kind,
    input  logic [WAIT_W-1:0]  wait_cycles,
    input  logic [ADDR_W-1:0]  base_addr,
    input  logic               bus_grant,
    output logic               bus_req,
    output logic               mem_rd,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic [31:0]        mem_rdata,
    output logic               pix_valid,
    output logic [23:0]        pix_data,
    output logic               line_done,
    output logic [STALL_W-1:0] stall_cycles,
    output logic               overrun
);
    localparam int WORDS_W = SEG_W + 1;
    localparam int BLK_LG  = $clog2(BLK_BYTES);
    localparam int BEAT_W  = WAIT_W + 1;

    fetch_st_e           state_q;
    mem_kind_e           kind_q;
    logic [WAIT_W-1:0]   wait_q;
    logic [WORDS_W-1:0]  left_q;
    logic [WORDS_W-1:0]  words_calc;
    logic [ADDR_W-1:0]   addr_q;
    logic [ADDR_W-1:0]   addr_nxt;
    logic                xing_q;
    logic                xing_nxt;
    logic [BEAT_W-1:0]   beat_q;
    logic [BEAT_W-1:0]   beat_need;
    logic [3:0]          ovh_q;
    logic                accept;
    logic                beat_last;
    logic                finish;

    lf_len_calc #(.SEG_W(SEG_W), .WORDS_W(WORDS_W)) u_len (
        .seg   (seg_count),
        .depth (depth_code),
        .kind  (mem_kind_e'(mem_kind)),
        .words (words_calc)
    );

    always_comb begin
        accept   = line_start && (state_q == ST_IDLE);
        addr_nxt = addr_q + (is_wide(kind_q) ? ADDR_W'(4) : ADDR_W'(2));
        xing_nxt = is_wide(kind_q) &&
                   (addr_nxt[ADDR_W-1:BLK_LG] != addr_q[ADDR_W-1:BLK_LG]);
        case (kind_q)
            MEM_IRAM32:  beat_need = BEAT_W'(xing_q);
            MEM_SDRAM16: beat_need = '0;
            default:     beat_need = {1'b0, wait_q} + BEAT_W'(1);
        endcase
        beat_last = (state_q == ST_READ) && (beat_q == beat_need);
        finish    = beat_last && (left_q == WORDS_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            kind_q    <= MEM_SRAM16;
            wait_q    <= '0;
            left_q    <= '0;
            addr_q    <= '0;
            xing_q    <= 1'b0;
            beat_q    <= '0;
            ovh_q     <= '0;
            pix_valid <= 1'b0;
            pix_data  <= '0;
            overrun   <= 1'b0;
        end else begin
            pix_valid <= 1'b0;
            if (line_start)
                overrun <= !accept;
            case (state_q)
                ST_IDLE: if (line_start) begin
                    kind_q  <= mem_kind_e'(mem_kind);
                    wait_q  <= wait_cycles;
                    addr_q  <= base_addr;
                    left_q  <= words_calc;
                    xing_q  <= 1'b0;
                    beat_q  <= '0;
                    state_q <= ST_REQ;
                end
                ST_REQ: if (bus_grant) begin
                    case (kind_q)
                        MEM_SDRAM16: begin
                            ovh_q   <= 4'(SDRAM_LINE_OVH - 1);
                            state_q <= ST_OVH;
                        end
                        MEM_IRAM32: begin
                            ovh_q   <= 4'(IRAM_LINE_OVH - 1);
                            state_q <= ST_OVH;
                        end
                        default: state_q <= ST_READ;
                    endcase
                end
                ST_OVH: begin
                    if (ovh_q == 4'd0)
                        state_q <= ST_READ;
                    else
                        ovh_q <= ovh_q - 4'd1;
                end
                ST_READ: begin
                    if (beat_last) begin
                        pix_valid <= 1'b1;
                        pix_data  <= is_wide(kind_q) ? mem_rdata[23:0]
                                                     : {8'h00, mem_rdata[15:0]};
                        beat_q    <= '0;
                        if (finish) begin
                            state_q <= ST_IDLE;
                        end else begin
                            left_q <= left_q - WORDS_W'(1);
                            addr_q <= addr_nxt;
                            xing_q <= xing_nxt;
                        end
                    end else begin
                        beat_q <= beat_q + BEAT_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign bus_req  = (state_q != ST_IDLE);
    assign mem_rd   = (state_q == ST_READ);
    assign mem_addr = addr_q;

    lf_stall_meter #(.W(STALL_W)) u_meter (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .active  ((state_q == ST_OVH) || (state_q == ST_READ)),
        .finish  (finish),
        .stall_q (stall_cycles),
        .done_q  (line_done)
    );

    p_req_after_start_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> $past(line_start));
    p_rd_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> bus_req);
    p_done_releases_r6: assert property (@(posedge clk) disable iff (rst)
        line_done |-> !bus_req);
    p_overrun_set_r7: assert property (@(posedge clk) disable iff (rst)
        (line_start && bus_req) |=> overrun);
    p_pix_from_read_r8: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> $past(mem_rd));

endmodule

// File: tb/line_fetch_master_test.sv
module line_fetch_master_test;
    localparam int CLK_PERIOD = 10;
    localparam int SEG_W   = 11;
    localparam int WAIT_W  = 4;
    localparam int ADDR_W  = 24;
    localparam int BLK     = 256;
    localparam int STALL_W = SEG_W + WAIT_W + 3;
    localparam int NVEC    = 8;

    typedef struct packed {
        logic [10:0] seg;
        logic [2:0]  depth;
        logic [1:0]  mem;
        logic [3:0]  wt;
        logic [23:0] base;
        logic [3:0]  gdly;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{11'd320, 3'd0, 2'd0, 4'd0, 24'h000000, 4'd0},
        '{11'd320, 3'd3, 2'd0, 4'd2, 24'h001000, 4'd1},
        '{11'd100, 3'd4, 2'd1, 4'd0, 24'h000100, 4'd0},
        '{11'd200, 3'd6, 2'd1, 4'd0, 24'h0000F0, 4'd2},
        '{11'd64,  3'd5, 2'd2, 4'd0, 24'h000400, 4'd0},
        '{11'd50,  3'd1, 2'd2, 4'd7, 24'h000010, 4'd5},
        '{11'd3,   3'd2, 2'd0, 4'd5, 24'h000200, 4'd0},
        '{11'd10,  3'd7, 2'd3, 4'd1, 24'h000300, 4'd3}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_start = 1'b0;
    logic [SEG_W-1:0] seg_count = '0;
    logic [2:0] depth_code = '0;
    logic [1:0] mem_kind = '0;
    logic [WAIT_W-1:0] wait_cycles = '0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic bus_grant = 1'b0;
    logic bus_req, mem_rd, pix_valid, line_done, overrun;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0] mem_rdata;
    logic [23:0] pix_data;
    logic [STALL_W-1:0] stall_cycles;

    int n_checks = 0;
    int n_fail = 0;
    int pix_idx = 0;
    int pix_bad = 0;
    vec_t cur;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = {8'hC3, mem_addr ^ 24'h3C3C3C};

    line_fetch_master #(
        .SEG_W(SEG_W), .WAIT_W(WAIT_W), .ADDR_W(ADDR_W),
        .BLK_BYTES(BLK), .STALL_W(STALL_W)
    ) uut (
        .clk(clk), .rst(rst), .line_start(line_start), .seg_count(seg_count),
        .depth_code(depth_code), .mem_kind(mem_kind), .wait_cycles(wait_cycles),
        .base_addr(base_addr), .bus_grant(bus_grant), .bus_req(bus_req),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .pix_valid(pix_valid), .pix_data(pix_data), .line_done(line_done),
        .stall_cycles(stall_cycles), .overrun(overrun)
    );

    function automatic int bpp_of(input logic [2:0] d);
        int t [8] = '{1, 2, 4, 8, 12, 16, 24, 24};
        return t[d];
    endfunction

    function automatic int words_of(input vec_t v);
        int w = (v.mem == 2'd1) ? 32 : 16;
        return (int'(v.seg) * bpp_of(v.depth) + w - 1) / w;
    endfunction

    function automatic int stall_of(input vec_t v);
        int n = words_of(v);
        int x = 0;
        if (v.mem == 2'd1) begin
            for (int i = 1; i < n; i++)
                if (((int'(v.base) + 4*i) / BLK) != ((int'(v.base) + 4*(i-1)) / BLK))
                    x++;
            return 1 + n + x;
        end
        if (v.mem == 2'd2) return 9 + n;
        return n * (2 + int'(v.wt));
    endfunction

    function automatic logic [23:0] pix_exp(input vec_t v, input int i);
        logic [23:0] a;
        int step = (v.mem == 2'd1) ? 4 : 2;
        a = 24'(int'(v.base) + step*i) ^ 24'h3C3C3C;
        return (v.mem == 2'd1) ? a : {8'h00, a[15:0]};
    endfunction

    always @(negedge clk) begin
        if (!rst && pix_valid) begin
            if (pix_data !== pix_exp(cur, pix_idx)) pix_bad++;
            pix_idx++;
        end
    end

    task automatic check(input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic start_line(input vec_t v);
        @(negedge clk);
        seg_count = v.seg; depth_code = v.depth; mem_kind = v.mem;
        wait_cycles = v.wt; base_addr = v.base;
        cur = v; pix_idx = 0; pix_bad = 0;
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        seg_count = '0;
        depth_code = 3'd6;
        check("R2", "bus_req after start", longint'(bus_req), 1);
    endtask

    task automatic finish_line(input vec_t v);
        string t;
        int n = 0;
        while (!line_done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        t = (v.mem == 2'd1) ? "R4" : (v.mem == 2'd2) ? "R5" : "R3";
        check(t, "stall cycles (R6 latch)", longint'(stall_cycles), stall_of(v));
        check("R6", "bus_req low at done", longint'(bus_req), 0);
        @(negedge clk);
        check("R1", "pixel beats", pix_idx, words_of(v));
        check("R8", "pixel data mismatches", pix_bad, 0);
        bus_grant = 1'b0;
    endtask

    task automatic run_line(input vec_t v);
        start_line(v);
        repeat (int'(v.gdly)) @(negedge clk);
        bus_grant = 1'b1;
        finish_line(v);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        vec_t ov;
        vec_t ov_next;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check("R9", "bus_req", longint'(bus_req), 0);
        check("R9", "mem_rd", longint'(mem_rd), 0);
        check("R9", "pix_valid", longint'(pix_valid), 0);
        check("R9", "line_done", longint'(line_done), 0);
        check("R9", "overrun", longint'(overrun), 0);
        check("R9", "stall_cycles", longint'(stall_cycles), 0);

        for (int k = 0; k < NVEC; k++) run_line(VECS[k]);

        // R7: start while busy is dropped and flagged
        ov = '{11'd320, 3'd0, 2'd0, 4'd0, 24'h000800, 4'd0};
        start_line(ov);
        bus_grant = 1'b1;
        repeat (4) @(negedge clk);
        seg_count = 11'd7; mem_kind = 2'd2; line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        check("R7", "overrun set", longint'(overrun), 1);
        finish_line(ov);
        check("R7", "overrun held after line", longint'(overrun), 1);
        ov_next = '{11'd16, 3'd3, 2'd2, 4'd0, 24'h000040, 4'd0};
        start_line(ov_next);
        check("R7", "overrun cleared by accepted start", longint'(overrun), 0);
        bus_grant = 1'b1;
        finish_line(ov_next);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule